// File: doc/BRIEF.md
# Display Interrupt Status and Deferred Register Commit

This block gathers the timing events of a display pipeline (vertical sync, the end of each interlaced field, the end of the active frame, and starvation of the video and graphics fetch FIFOs) into sticky status bits. It drives one interrupt line from the status bits whose enable bits are set. Software reads and acknowledges the status through a simple word-wide register port. A configuration bit makes a status read destructive.

The same block holds a bank of shadowed timing registers. Software first stages a value and a keep-mask for each target register. It then arms a commit. At the next end-of-active-frame event the block updates every target at once as `(old & mask) | value`, clears its pending flag, and turns off the frame-end enable that the commit turned on. A page-flip completion pulse follows on the first vertical sync at which nothing is pending. The block also keeps a field indicator that tells the timing generator which parameter set to load for the next field.

Top module: `disp_irq_commit`

## Requirements
- R1: After reset the status, enable, clean-on-read bit, pending flag, staging and target registers are all zero, and `irq`, `next_field` and `flip_done` are low.
- R2: Each event input pulse sets its sticky status bit, whether or not that bit is enabled. The status bit positions are: 0 vertical sync, 1 field-0 done, 2 field-1 done, 3 frame end, 4 video underflow, 5 graphics underflow. Status is read at address 0.
- R3: `irq` rises one cycle after some status bit is set together with its enable bit (enable register at address 1, same bit positions). `irq` never rises while no enabled status bit is set. Once high, it stays high.
- R4: A write to address 0 clears the status bits set in the written data and drops `irq` at that edge. Without such a write, `irq` stays asserted and gives no new rising edge. If enabled status remains after the write, `irq` rises again one cycle later.
- R5: Bit 31 of the enable register turns on clean-on-read. With it set, a status read clears exactly the bits it returned. With it clear, reads leave the status unchanged.
- R6: Any enable bit that goes from 0 to 1 clears its status bit at the same edge, so a stale event cannot raise `irq`.
- R7: `next_field` goes to 1 on a field-1 done event and to 0 on a field-0 done event. Field 1 takes priority when both occur in the same cycle.
- R8: The staging value for target i is at address 8+2i and its keep-mask is at 9+2i. Writing 1 to bit 0 of address 2 sets the pending flag (bit 0 of address 2) and the frame-end enable bit. At the next frame-end event that finds both set, every target becomes `(old & mask) | value`, and pending and the frame-end enable clear. Until then the targets hold. Targets read at address 16+i and appear on `tgt_regs`.
- R9: After a commit, `flip_done` pulses for one cycle following the first vertical sync event that finds nothing pending. A vertical sync that coincides with the applying frame-end event does not complete the flip. Bit 1 of address 2 shows that a flip is still waiting.
- R10: An event in the same cycle as a clear of its status bit (acknowledge write, clean-on-read, or enable rise) wins, and the bit is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_vsync | input | 1 | Vertical sync event pulse |
| ev_field0_done | input | 1 | Field 0 finished |
| ev_field1_done | input | 1 | Field 1 finished |
| ev_frame_end | input | 1 | End of active frame |
| ev_video_urun | input | 1 | Video fetch FIFO underflow |
| ev_gfx_urun | input | 1 | Graphics fetch FIFO underflow |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | ADDR_W | Register word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |
| next_field | output | 1 | Field whose timing set loads next |
| flip_done | output | 1 | One-cycle flip completion pulse |
| tgt_regs | output | NUM_TGT*DATA_W | Committed target registers, target 0 in the low word |

## Verification
The risky overlaps are an event arriving in the same cycle as software clearing the same status bit, and a frame-end commit arriving in the same cycle as a vertical sync. The bench forces both on purpose. It drives an event in the same cycle as an acknowledge write, as a clean-on-read status read, and as an enable write with a rising bit, and expects the bit to survive each time. It pulses frame end and vertical sync together while a commit is pending, and expects the targets to update, no flip pulse at that point, and a flip pulse only on the following vertical sync. Random operation sequences against a bench model then check the interrupt line, the status and the targets.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int EV_N     = 6;
  localparam int EV_VSYNC = 0;
  localparam int EV_FLD0  = 1;
  localparam int EV_FLD1  = 2;
  localparam int EV_FEND  = 3;
  localparam int EV_VURUN = 4;
  localparam int EV_GURUN = 5;

  localparam int ADR_STATUS = 0;
  localparam int ADR_ENABLE = 1;
  localparam int ADR_COMMIT = 2;
  localparam int ADR_STAGE  = 8;

  typedef struct packed {
    logic st_wr;
    logic st_rd;
    logic en_wr;
    logic cm_wr;
  } cpu_dec_t;
endpackage

// File: rtl/disp_irq_status.sv
module disp_irq_status
  import disp_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_N-1:0] ev,
  input  cpu_dec_t        dec,
  input  logic [EV_N-1:0] wr_bits,
  input  logic            wr_clean,
  input  logic            fe_en_set,
  input  logic            fe_en_clr,
  output logic [EV_N-1:0] status,
  output logic [EV_N-1:0] enable,
  output logic            clean_rd,
  output logic            irq
);
  logic [EV_N-1:0] st_q, st_n, en_q, en_n, rise, clr;
  logic            clean_q, clean_n, irq_q, irq_n, en_ld;

  // enable register: software write, then commit engine overrides on frame-end bit
  always_comb begin
    en_n = en_q;
    if (dec.en_wr) en_n = wr_bits;
    if (fe_en_clr) en_n[EV_FEND] = 1'b0;
    if (fe_en_set) en_n[EV_FEND] = 1'b1;
    en_ld   = dec.en_wr | fe_en_set | fe_en_clr;
    clean_n = dec.en_wr ? wr_clean : clean_q;
  end

  // status: clears from ack, clean read and enable rise; new events override
  always_comb begin
    rise = en_ld ? (en_n & ~en_q) : '0;
    clr  = rise;
    if (dec.st_wr)            clr = clr | wr_bits;
    if (dec.st_rd && clean_q) clr = clr | st_q;
    st_n = (st_q & ~clr) | ev;
  end

  // interrupt line latches until acknowledged
  always_comb begin
    irq_n = irq_q;
    if (dec.st_wr)            irq_n = 1'b0;
    else if (|(st_q & en_q))  irq_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      en_q    <= '0;
      clean_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      st_q  <= st_n;
      irq_q <= irq_n;
      if (en_ld)     en_q    <= en_n;
      if (dec.en_wr) clean_q <= clean_n;
    end
  end

  assign status   = st_q;
  assign enable   = en_q;
  assign clean_rd = clean_q;
  assign irq      = irq_q;
endmodule

// File: rtl/disp_shadow_commit.sv
module disp_shadow_commit #(
  parameter int NUM_TGT  = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int STG_BASE = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      commit_wr,
  input  logic                      ev_fend,
  input  logic                      ev_vsync,
  input  logic                      fe_enabled,
  output logic                      pending,
  output logic                      flip_wait,
  output logic                      fe_en_set,
  output logic                      fe_en_clr,
  output logic                      flip_done,
  output logic [NUM_TGT*DATA_W-1:0] tgt_flat
);
  logic apply;
  logic pend_q, pend_n, flip_q, flip_n, done_q, done_n;

  assign apply     = ev_fend & pend_q & fe_enabled;
  assign fe_en_set = commit_wr;
  assign fe_en_clr = apply;

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
    localparam int VAL_ADR = STG_BASE + 2 * i;
    localparam int MSK_ADR = VAL_ADR + 1;
    logic [DATA_W-1:0] val_q, msk_q, tgt_q, tgt_n;
    logic val_we, msk_we;

    always_comb begin
      val_we = wr && (addr == ADDR_W'(VAL_ADR));
      msk_we = wr && (addr == ADDR_W'(MSK_ADR));
      tgt_n  = (tgt_q & msk_q) | val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        msk_q <= '0;
        tgt_q <= '0;
      end else begin
        if (val_we) val_q <= wdata;
        if (msk_we) msk_q <= wdata;
        if (apply)  tgt_q <= tgt_n;
      end
    end

    assign tgt_flat[i*DATA_W +: DATA_W] = tgt_q;
  end

  always_comb begin
    pend_n = pend_q;
    if (apply)     pend_n = 1'b0;
    if (commit_wr) pend_n = 1'b1;
    done_n = ev_vsync & flip_q & ~pend_q;
    flip_n = flip_q;
    if (done_n)    flip_n = 1'b0;
    if (commit_wr) flip_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      flip_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      flip_q <= flip_n;
      done_q <= done_n;
    end
  end

  assign pending   = pend_q;
  assign flip_wait = flip_q;
  assign flip_done = done_q;
endmodule

// File: rtl/disp_irq_commit.sv
module disp_irq_commit
  import disp_irq_pkg::*;
#(
  parameter int NUM_TGT = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ev_vsync,
  input  logic                      ev_field0_done,
  input  logic                      ev_field1_done,
  input  logic                      ev_frame_end,
  input  logic                      ev_video_urun,
  input  logic                      ev_gfx_urun,
  input  logic                      cpu_wr,
  input  logic                      cpu_rd,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [DATA_W-1:0]         cpu_wdata,
  output logic [DATA_W-1:0]         cpu_rdata,
  output logic                      irq,
  output logic                      next_field,
  output logic                      flip_done,
  output logic [NUM_TGT*DATA_W-1:0] tgt_regs
);
  localparam int TGT_BASE = ADR_STAGE + 2 * NUM_TGT;

  logic [EV_N-1:0] ev, st_w, en_w;
  cpu_dec_t        dec;
  logic            clean_w, pend_w, flipw_w, fe_set, fe_clr;
  logic            fld_q, fld_n, fld_ld;

  assign ev = {ev_gfx_urun, ev_video_urun, ev_frame_end,
               ev_field1_done, ev_field0_done, ev_vsync};

  always_comb begin
    dec.st_wr = cpu_wr && (cpu_addr == ADDR_W'(ADR_STATUS));
    dec.st_rd = cpu_rd && (cpu_addr == ADDR_W'(ADR_STATUS));
    dec.en_wr = cpu_wr && (cpu_addr == ADDR_W'(ADR_ENABLE));
    dec.cm_wr = cpu_wr && (cpu_addr == ADDR_W'(ADR_COMMIT)) && cpu_wdata[0];
  end

  disp_irq_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .dec      (dec),
    .wr_bits  (cpu_wdata[EV_N-1:0]),
    .wr_clean (cpu_wdata[DATA_W-1]),
    .fe_en_set(fe_set),
    .fe_en_clr(fe_clr),
    .status   (st_w),
    .enable   (en_w),
    .clean_rd (clean_w),
    .irq      (irq)
  );

  disp_shadow_commit #(
    .NUM_TGT (NUM_TGT),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .STG_BASE(ADR_STAGE)
  ) u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (cpu_wr),
    .addr      (cpu_addr),
    .wdata     (cpu_wdata),
    .commit_wr (dec.cm_wr),
    .ev_fend   (ev_frame_end),
    .ev_vsync  (ev_vsync),
    .fe_enabled(en_w[EV_FEND]),
    .pending   (pend_w),
    .flip_wait (flipw_w),
    .fe_en_set (fe_set),
    .fe_en_clr (fe_clr),
    .flip_done (flip_done),
    .tgt_flat  (tgt_regs)
  );

  // field indicator: field 1 has priority
  always_comb begin
    fld_ld = ev_field0_done | ev_field1_done;
    fld_n  = ev_field1_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fld_q <= 1'b0;
    else if (fld_ld) fld_q <= fld_n;
  end
  assign next_field = fld_q;

  always_comb begin
    cpu_rdata = '0;
    if (cpu_addr == ADDR_W'(ADR_STATUS)) cpu_rdata = DATA_W'(st_w);
    if (cpu_addr == ADDR_W'(ADR_ENABLE)) begin
      cpu_rdata = DATA_W'(en_w);
      cpu_rdata[DATA_W-1] = clean_w;
    end
    if (cpu_addr == ADDR_W'(ADR_COMMIT)) cpu_rdata = DATA_W'({flipw_w, pend_w});
    for (int i = 0; i < NUM_TGT; i++) begin
      if (cpu_addr == ADDR_W'(TGT_BASE + i)) cpu_rdata = tgt_regs[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/disp_irq_commit_chk.sv
module disp_irq_commit_chk
  import disp_irq_pkg::*;
#(
  parameter int NUM_TGT = 4,
  parameter int DATA_W  = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [EV_N-1:0]           ev,
  input logic                      irq,
  input logic [EV_N-1:0]           status,
  input logic [EV_N-1:0]           enable,
  input logic                      pending,
  input logic                      commit_wr,
  input logic                      flip_done,
  input logic [NUM_TGT*DATA_W-1:0] tgt_flat
);
  a_r3_irq_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(status & enable)));

  a_r8_apply_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[EV_FEND] && pending && enable[EV_FEND] && !commit_wr) |=> (!pending && !enable[EV_FEND]));

  a_r8_targets_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev[EV_FEND] && pending && enable[EV_FEND]) |=> $stable(tgt_flat));

  a_r9_flip_idle_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    flip_done |-> ($past(ev[EV_VSYNC]) && !$past(pending)));

  a_r9_flip_single: assert property (@(posedge clk) disable iff (!rst_n)
    flip_done |=> !flip_done);

  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((status & $past(ev)) == $past(ev)));
endmodule

bind disp_irq_commit disp_irq_commit_chk #(.NUM_TGT(NUM_TGT), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ev       (ev),
  .irq      (irq),
  .status   (st_w),
  .enable   (en_w),
  .pending  (pend_w),
  .commit_wr(dec.cm_wr),
  .flip_done(flip_done),
  .tgt_flat (tgt_regs)
);

// File: tb/disp_irq_commit_bench.sv
module disp_irq_commit_bench;
  localparam int NT = 4;
  logic clk, rst_n, cpu_wr, cpu_rd, irq, next_field, flip_done;
  logic [5:0] ev;
  logic [4:0] cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic [NT*32-1:0] tgt_regs;
  int n_chk = 0, n_fail = 0;

  logic [5:0]  m_st, m_en;
  logic        m_clean, m_pend, m_irq;
  logic [31:0] m_tg [NT];
  logic [31:0] m_sv [NT];
  logic [31:0] m_sm [NT];

  disp_irq_commit #(.NUM_TGT(NT), .DATA_W(32), .ADDR_W(5)) u_disp_irq_commit (
    .clk(clk), .rst_n(rst_n),
    .ev_vsync(ev[0]), .ev_field0_done(ev[1]), .ev_field1_done(ev[2]),
    .ev_frame_end(ev[3]), .ev_video_urun(ev[4]), .ev_gfx_urun(ev[5]),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .irq(irq), .next_field(next_field), .flip_done(flip_done), .tgt_regs(tgt_regs));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] m, logic [31:0] v);
    return (o & m) | v;
  endfunction

  function automatic logic [31:0] en_word(logic c, logic [5:0] e);
    return {c, 25'b0, e};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus_write(int a, logic [31:0] d);
    cpu_wr = 1'b1; cpu_addr = 5'(a); cpu_wdata = d;
    tick();
    cpu_wr = 1'b0;
  endtask

  task automatic bus_read(int a, output logic [31:0] d);
    cpu_rd = 1'b1; cpu_addr = 5'(a);
    #1 d = cpu_rdata;
    tick();
    cpu_rd = 1'b0;
  endtask

  task automatic pulse(logic [5:0] v);
    ev = v;
    tick();
    ev = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; ev = '0; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 next_field", next_field, 0);
    chk("R1 flip_done", flip_done, 0);
    chk("R1 targets", tgt_regs[31:0] | tgt_regs[63:32] | tgt_regs[95:64] | tgt_regs[127:96], 0);
    bus_read(0, d); chk("R1 status", d, 0);
    bus_read(1, d); chk("R1 enable", d, 0);
    bus_read(2, d); chk("R1 commit", d, 0);

    // R2/R3 unenabled events recorded, no interrupt
    pulse(6'b110000);
    bus_read(0, d); chk("R2 status sticky", d, 32'h30);
    tick(); chk("R3 no irq unenabled", irq, 0);

    // R6 enable rise clears stale status
    bus_write(1, 32'h20);
    bus_read(0, d); chk("R6 stale cleared", d, 32'h10);
    tick(); chk("R6 no irq after stale clear", irq, 0);

    // R5 non-destructive, then clean-on-read
    bus_read(0, d); chk("R5 read keeps", d, 32'h10);
    bus_write(1, 32'h8000_0001);
    bus_read(1, d); chk("R5 enable readback", d, 32'h8000_0001);
    bus_read(0, d); chk("R5 clean read value", d, 32'h10);
    bus_read(0, d); chk("R5 cleared by read", d, 0);

    // R3/R4 interrupt and acknowledge
    pulse(6'b000001);
    chk("R3 irq delay", irq, 0);
    tick(); chk("R3 irq raised", irq, 1);
    bus_read(0, d); chk("R3 status", d, 1);
    tick(); chk("R4 irq held without ack", irq, 1);
    pulse(6'b000001);
    tick(); chk("R4 still held", irq, 1);
    bus_write(0, 32'h0);
    chk("R4 ack drops irq", irq, 0);
    tick(); chk("R4 re-raise", irq, 1);
    bus_write(0, 32'h1);
    tick(); tick(); chk("R4 ack cleared", irq, 0);
    bus_read(0, d); chk("R4 status cleared", d, 0);

    // R7 field indicator
    pulse(6'b000100); chk("R7 field1", next_field, 1);
    pulse(6'b000010); chk("R7 field0", next_field, 0);
    pulse(6'b000110); chk("R7 both field1 wins", next_field, 1);
    bus_read(0, d); chk("R2 field status bits", d, 32'h6);

    // R10 event beats ack write
    ev = 6'b000001; cpu_wr = 1'b1; cpu_addr = 5'd0; cpu_wdata = 32'h1;
    tick(); ev = '0; cpu_wr = 1'b0;
    bus_read(0, d); chk("R10 event beats ack", d, 32'h1);
    // R10 event beats clean read
    ev = 6'b010000; cpu_rd = 1'b1; cpu_addr = 5'd0;
    tick(); ev = '0; cpu_rd = 1'b0;
    bus_read(0, d); chk("R10 event beats clean read", d, 32'h10);
    // R10 event beats enable rise
    ev = 6'b010000; cpu_wr = 1'b1; cpu_addr = 5'd1; cpu_wdata = 32'h10;
    tick(); ev = '0; cpu_wr = 1'b0;
    bus_read(0, d); chk("R10 event beats stale clear", d, 32'h10);
    bus_write(1, 0); bus_write(0, 32'h3f);
    tick(); chk("R4 idle irq", irq, 0);

    // R8/R9 commit
    bus_write(8, 32'h1234_5678); bus_write(9, 32'h0);
    bus_write(10, 32'h0000_00A5); bus_write(11, 32'hFFFF_FF00);
    bus_write(2, 32'h1);
    bus_read(2, d); chk("R8 pending set", d, 32'h3);
    bus_read(1, d); chk("R8 frame-end enable set", d, 32'h8);
    chk("R8 targets hold", tgt_regs[31:0], 0);
    pulse(6'b000001); chk("R9 no flip while pending", flip_done, 0);
    pulse(6'b001000);
    chk("R8 target0 applied", tgt_regs[31:0], 32'h1234_5678);
    chk("R8 target1 applied", tgt_regs[63:32], 32'hA5);
    bus_read(2, d); chk("R8 pending cleared", d, 32'h2);
    bus_read(1, d); chk("R8 frame-end enable cleared", d, 32'h0);
    bus_read(17, d); chk("R8 target1 readback", d, 32'hA5);
    pulse(6'b000001); chk("R9 flip pulse", flip_done, 1);
    tick(); chk("R9 flip single cycle", flip_done, 0);
    bus_read(2, d); chk("R9 flip no longer waiting", d, 0);

    bus_write(10, 32'h0000_3C00); bus_write(11, 32'h0000_00FF);
    bus_write(2, 32'h1);
    pulse(6'b001001);
    chk("R9 no flip on applying vsync", flip_done, 0);
    chk("R8 masked merge", tgt_regs[63:32], 32'h3CA5);
    pulse(6'b000001); chk("R9 flip next vsync", flip_done, 1);
    tick();

    // random phase against the model
    bus_write(1, 0); bus_write(0, 32'h3f);
    m_st = '0; m_en = '0; m_clean = 1'b0; m_pend = 1'b0; m_irq = 1'b0;
    m_tg[0] = 32'h1234_5678; m_tg[1] = 32'h3CA5; m_tg[2] = 0; m_tg[3] = 0;
    m_sv[0] = 32'h1234_5678; m_sm[0] = 0; m_sv[1] = 32'h3C00; m_sm[1] = 32'hFF;
    m_sv[2] = 0; m_sm[2] = 0; m_sv[3] = 0; m_sm[3] = 0;
    tick();
    for (int it = 0; it < 80; it++) begin
      int op;
      int t;
      logic [5:0] evv;
      logic [31:0] v, mk;
      op = $urandom_range(0, 5);
      case (op)
        0: begin
          evv = 6'($urandom);
          pulse(evv);
          if (evv[3] && m_pend && m_en[3]) begin
            for (int k = 0; k < NT; k++) m_tg[k] = merge(m_tg[k], m_sm[k], m_sv[k]);
            m_pend = 1'b0; m_en[3] = 1'b0;
          end
          m_st = m_st | evv;
        end
        1: begin
          v = $urandom;
          bus_write(1, v);
          m_st = m_st & ~(v[5:0] & ~m_en);
          m_en = v[5:0]; m_clean = v[31];
        end
        2: begin
          v = $urandom;
          bus_write(0, v);
          m_st = m_st & ~v[5:0]; m_irq = 1'b0;
        end
        3: begin
          bus_read(0, d);
          chk("R5 random status", d, {26'b0, m_st});
          if (m_clean) m_st = '0;
        end
        4: begin
          t = $urandom_range(0, NT - 1);
          v = $urandom; mk = $urandom;
          bus_write(8 + 2 * t, v); bus_write(9 + 2 * t, mk);
          m_sv[t] = v; m_sm[t] = mk;
          bus_write(2, 1);
          m_pend = 1'b1;
          if (!m_en[3]) begin m_st[3] = 1'b0; m_en[3] = 1'b1; end
        end
        default: begin
          bus_read(1, d);
          chk("R6 random enable", d, en_word(m_clean, m_en));
        end
      endcase
      tick(); tick();
      if (|(m_st & m_en)) m_irq = 1'b1;
      chk("R3 random irq", irq, m_irq);
      t = $urandom_range(0, NT - 1);
      chk("R8 random target", tgt_regs[t*32 +: 32], m_tg[t]);
    end
    summary();
  end
endmodule